// File: doc/BRIEF.md
# Demand-Driven Two-Road Light Controller

This block drives the lights at a crossing of two roads, north-south and east-west, that have only green and red lamps. It is a Moore machine with two phases. In each phase one road has green and the other has red, so neither all-red nor all-green can appear. A car detector on each road tells the controller whether traffic is waiting.

A programmable prescaler divides the clock down to a one-cycle decision strobe, once per decision period (thirty seconds by default). The phase can only change on a clock edge where that strobe is high. At that edge the phase changes only if a car is waiting on the road that currently shows red. A car on the road that already has green does not matter. Both detector lines pass through a two-flop synchroniser before the decision logic uses them.

Top module: `crossing_ctrl`

## Requirements
- R1: On every cycle exactly one of `ns_green_o` and `ew_green_o` is 1. `phase_o` is 0 when north-south has green and 1 when east-west has green.
- R2: A synchronous reset (`rst` high at a clock edge) sets the phase to north-south green and clears the prescaler. The first decision edge after reset is the TICK_DIV-th clock edge after `rst` falls.
- R3: Decision edges come every TICK_DIV = CLK_HZ × PERIOD_S clocks. Between decision edges the phase and both greens do not change.
- R4: In the north-south phase, a decision edge that sees the east-west detector at 1 moves the phase to east-west, whatever the north-south detector shows.
- R5: In the north-south phase, a decision edge that sees the east-west detector at 0 keeps the phase.
- R6: In the east-west phase, a decision edge that sees the north-south detector at 1 moves the phase to north-south, whatever the east-west detector shows.
- R7: In the east-west phase, a decision edge that sees the north-south detector at 0 keeps the phase.
- R8: The detector level a decision acts on is the level present at the clock edge two cycles before the decision edge. A detector pulse that ends before that edge, or that begins after it, has no effect on that decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ns_car_i | input | 1 | North-south car detector, asynchronous |
| ew_car_i | input | 1 | East-west car detector, asynchronous |
| ns_green_o | output | 1 | North-south green lamp |
| ew_green_o | output | 1 | East-west green lamp |
| phase_o | output | 1 | Current phase: 0 north-south green, 1 east-west green |

## Verification
A detector level sampled at clock edge T decides the phase at edge T+2 if that edge is a decision edge. The new phase and greens are then visible from that edge on. A reset takes effect at the same edge it is sampled. The bench drives the inputs at falling edges and always measures in TICK_DIV-edge periods counted from reset release. It checks the lamps at every falling edge: they must be unchanged for the first TICK_DIV-1 edges of a period and show the modelled decision after the last edge. The model reads the detector value that was driven before the third edge from the end of the period.

// File: rtl/crossing_pkg.sv
package crossing_pkg;

  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_e;

  // Next phase for a decision edge: move only if the red road has demand.
  function automatic phase_e phase_step(phase_e cur, logic ns_car, logic ew_car);
    phase_e nxt;
    nxt = cur;
    case (cur)
      PH_NS:   if (ew_car) nxt = PH_EW;
      PH_EW:   if (ns_car) nxt = PH_NS;
      default: nxt = PH_NS;
    endcase
    return nxt;
  endfunction

  // Lamp pair {ew, ns} for a phase.
  function automatic logic [1:0] lamps_of(phase_e p);
    return (p == PH_EW) ? 2'b10 : 2'b01;
  endfunction

  // Width of a counter that must hold 0..limit-1.
  function automatic int count_width(longint limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter longint DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  import crossing_pkg::*;

  localparam int CW = count_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/car_sync.sv
module car_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LASTS = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= raw_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[LASTS];
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                ns_seen_i,
  input  logic                ew_seen_i,
  output crossing_pkg::phase_e phase_o
);
  import crossing_pkg::*;

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick_i) phase_d = phase_step(phase_q, ns_seen_i, ew_seen_i);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_NS;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/crossing_ctrl.sv
module crossing_ctrl #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PERIOD_S    = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ns_car_i,
  input  logic ew_car_i,
  output logic ns_green_o,
  output logic ew_green_o,
  output logic phase_o
);
  import crossing_pkg::*;

  localparam longint TICK_DIV = longint'(CLK_HZ) * longint'(PERIOD_S);

  logic       dec_tick;
  logic [1:0] seen;
  logic       ns_seen;
  logic       ew_seen;
  phase_e     phase_cur;
  logic [1:0] lamps;

  tick_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_o (dec_tick)
  );

  car_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  ({ew_car_i, ns_car_i}),
    .sync_o (seen)
  );

  assign ns_seen = seen[0];
  assign ew_seen = seen[1];

  phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (dec_tick),
    .ns_seen_i (ns_seen),
    .ew_seen_i (ew_seen),
    .phase_o   (phase_cur)
  );

  assign lamps      = lamps_of(phase_cur);
  assign ns_green_o = lamps[0];
  assign ew_green_o = lamps[1];
  assign phase_o    = phase_cur;
endmodule

// File: rtl/crossing_ctrl_chk.sv
module crossing_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ns_car_i,
  input logic ew_car_i,
  input logic ns_sync,
  input logic ew_sync,
  input logic tick,
  input logic phase,
  input logic ns_green,
  input logic ew_green
);
  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_one_green_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({ns_green, ew_green}) == 1 && ns_green == !phase);

  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (phase == 1'b0) && !tick);

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_ns_to_ew_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == 1'b0 && ew_sync) |=> phase == 1'b1);

  assert_ns_stay_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == 1'b0 && !ew_sync) |=> phase == 1'b0);

  assert_ew_to_ns_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == 1'b1 && ns_sync) |=> phase == 1'b0);

  assert_ew_stay_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == 1'b1 && !ns_sync) |=> phase == 1'b1);

  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> (ns_sync == $past(ns_car_i, 2) && ew_sync == $past(ew_car_i, 2)));
endmodule

bind crossing_ctrl crossing_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ns_car_i (ns_car_i),
  .ew_car_i (ew_car_i),
  .ns_sync  (ns_seen),
  .ew_sync  (ew_seen),
  .tick     (dec_tick),
  .phase    (phase_o),
  .ns_green (ns_green_o),
  .ew_green (ew_green_o)
);

// File: tb/crossing_ctrl_bench.sv
module crossing_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 4;
  localparam int SECS = 2;
  localparam int DIV  = HZ * SECS;
  localparam int TAP  = DIV - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ns_car = 1'b0;
  logic ew_car = 1'b0;
  logic ns_g, ew_g, ph;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  logic exp_ph = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crossing_ctrl #(.CLK_HZ(HZ), .PERIOD_S(SECS)) u_crossing_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ns_car_i   (ns_car),
    .ew_car_i   (ew_car),
    .ns_green_o (ns_g),
    .ew_green_o (ew_g),
    .phase_o    (ph)
  );

  // Rule model: NS phase (0) leaves on east-west demand, EW phase (1) leaves on north-south demand.
  function automatic logic model_next(logic cur, logic ns, logic ew);
    return cur ? !ns : ew;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_lamps();
    check("R1 ns_green", int'(ns_g), int'(!exp_ph));
    check("R1 ew_green", int'(ew_g), int'(exp_ph));
  endtask

  // Entered and left at a falling edge; bit j of a pattern is driven before edge j+1.
  task automatic run_period(logic [DIV-1:0] ns_pat, logic [DIV-1:0] ew_pat, string tag);
    string t;
    for (int j = 0; j < DIV; j++) begin
      ns_car = ns_pat[j];
      ew_car = ew_pat[j];
      @(posedge clk);
      @(negedge clk);
      if (j < DIV - 1) begin
        check("R3 hold", int'(ph), int'(exp_ph));
      end else begin
        if (tag != "") t = tag;
        else if (!exp_ph) t = ew_pat[TAP] ? "R4" : "R5";
        else              t = ns_pat[TAP] ? "R6" : "R7";
        exp_ph = model_next(exp_ph, ns_pat[TAP], ew_pat[TAP]);
        check(t, int'(ph), int'(exp_ph));
      end
      check_lamps();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_ph = 1'b0;
    check("R2 reset phase", int'(ph), 0);
    check_lamps();
  endtask

  localparam logic [DIV-1:0] ALL = '1;
  localparam logic [DIV-1:0] NONE = '0;

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset phase", int'(ph), 0);
    check("R2 reset ns_green", int'(ns_g), 1);
    check("R2 reset ew_green", int'(ew_g), 0);
    rst = 1'b0;

    // All four detector combinations in both phases.
    run_period(NONE, NONE, "");   // NS, 00 -> stay R5
    run_period(ALL,  NONE, "");   // NS, ns only -> stay R5
    run_period(ALL,  ALL,  "");   // NS, both -> EW R4
    run_period(NONE, NONE, "");   // EW, 00 -> stay R7
    run_period(NONE, ALL,  "");   // EW, ew only -> stay R7
    run_period(ALL,  ALL,  "");   // EW, both -> NS R6
    run_period(NONE, ALL,  "");   // NS, ew only -> EW R4
    run_period(ALL,  NONE, "");   // EW, ns only -> NS R6

    // R8: timing of detector pulses relative to the sampling edge.
    run_period(NONE, DIV'(8'b0001_1111), "R8 early pulse ignored");
    run_period(NONE, DIV'(8'b0010_0000), "R8 pulse at sample edge");
    run_period(DIV'(8'b1100_0000), NONE, "R8 late pulse ignored");

    // R2: reset mid-period while in EW restarts the prescaler.
    check("R2 pre-reset phase", int'(ph), 1);
    for (int k = 0; k < 3; k++) begin
      ns_car = 1'b0; ew_car = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    do_reset();
    run_period(NONE, ALL, "R2 first tick after reset");

    // Random traffic.
    for (int n = 0; n < 40; n++) begin
      run_period(DIV'($urandom), DIV'($urandom), "");
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule